// File: doc/BRIEF.md
# Command/Indication Channel Access Unit

This block sits between a frame-based TDM subscriber bus and a transceiver core. Once per frame it exchanges a command/indication (C/I) code in each direction. When processor access is off, the two sides are joined directly. When access is on, a processor can replace the code that goes to the core or to the bus, and it can watch the codes that arrive. The block checks a code from the bus for stability before accepting it. A code from the core is accepted as soon as it changes. Each accepted change raises a sticky interrupt flag and is held in a readable latch.

A channel-select bit picks where the processor works. Channel 0 carries a 4-bit code. Channel 1 carries a 6-bit code and is used to program a terminal device on the bus. While channel 1 is selected, channel 0 is joined directly between the bus and the core.

Every code port carries one value per frame, qualified by the frame strobe. These ports have no valid/ready handshake. Neither side can stall a TDM frame, so there is no back-pressure: a value is sampled on the strobe cycle whether or not anything consumes it. The register port is a plain single-cycle read/write port.

Top module: `ci_access_unit`

## Requirements
- R1: After reset, `core_cmd_o` and `bus_ch0_tx_o` are 4'hF, `bus_ch1_tx_o` is 6'h3F and `irq_o` is 0. Register reads return the following:
  - CTRL (addr 0) = 0.
  - STAT (addr 1) = 0.
  - BUS_RX (addr 3) = 8'h0F.
  - CORE_TX (addr 5) = 8'h0F.
  - BUS_TX (addr 6) = 8'h3F.
- R2: When CTRL bit 0 (enable) is 0, the outputs and flags behave as follows:
  - Each frame strobe copies `bus_ch0_rx_i` to `core_cmd_o`.
  - Each frame strobe copies `core_ind_i` to `bus_ch0_tx_o`.
  - `bus_ch1_tx_o` stays 6'h3F.
  - No STAT flag is set.
- R3: A bus code is accepted only when the same value is seen in two consecutive frames and differs from the last accepted value. Acceptance latches the value into BUS_RX (addr 3, zero-extended). With enable set, it also sets STAT bit 0.
- R4: A bus code that is present for only one frame never changes BUS_RX and never sets STAT bit 0.
- R5: With enable set, a frame in which `core_ind_i` differs from the previous frame's value sets STAT bit 1. The new value is readable in CORE_RX (addr 4).
- R6: A code written to CORE_TX (addr 5) or BUS_TX (addr 6) reaches the outputs only at the next frame strobe. The code outputs change only on the cycle after a frame strobe.
- R7: Write registers are not cleared by a transfer. A code written once is driven on every later frame until it is overwritten.
- R8: With enable set and CTRL bit 1 (channel select) set, the outputs and the filter behave as follows:
  - `bus_ch1_tx_o` carries the 6-bit BUS_TX.
  - The stability filter watches `bus_ch1_rx_i`.
  - `bus_ch0_rx_i` passes to `core_cmd_o` each frame.
  - `core_ind_i` passes to `bus_ch0_tx_o` each frame.
  - With channel select clear, `core_cmd_o` takes CORE_TX, `bus_ch0_tx_o` takes BUS_TX[3:0], and the filter watches channel 0.
- R9: STAT flags are sticky and are cleared by a read of STAT. A flag set in the same cycle as that read survives the read.
- R10: `irq_o` is the OR of the STAT flags ANDed with MASK (addr 2). Mask bit 0 enables STAT bit 0 and mask bit 1 enables STAT bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle strobe marking a frame boundary |
| bus_ch0_rx_i | input | 4 | Channel-0 C/I code received from the bus |
| bus_ch1_rx_i | input | 6 | Channel-1 C/I code received from the bus |
| core_ind_i | input | 4 | C/I indication from the transceiver core |
| core_cmd_o | output | 4 | C/I command to the transceiver core |
| bus_ch0_tx_o | output | 4 | Channel-0 C/I code sent to the bus |
| bus_ch1_tx_o | output | 6 | Channel-1 C/I code sent to the bus |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a STAT read clears the flags) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the filter with single-frame glitches, with two different values in a row, and with a return to the accepted value. A filter that looked at only one frame would latch the glitch. A filter that ignored the accepted value would flag a repeat.

The bench checks the outputs before and after the first strobe that follows a write. A design that drove writes through at once would change `core_cmd_o` early. A design that cleared write registers after a transfer would stop sending the code on later frames.

The bench also issues a status read in the same cycle as a new acceptance. A clear-wins flag would lose that event.

Finally, the bench switches to channel 1. A wrong select would leave channel 0 under processor control instead of joining it through.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int CI0_W = 4;
  localparam int CI1_W = 6;
  localparam int REG_DW = 8;
  localparam int REG_AW = 3;

  localparam logic [CI0_W-1:0] IDLE0 = '1;
  localparam logic [CI1_W-1:0] IDLE1 = '1;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_STAT   = 3'd1;
  localparam logic [REG_AW-1:0] A_MASK   = 3'd2;
  localparam logic [REG_AW-1:0] A_BUSRX  = 3'd3;
  localparam logic [REG_AW-1:0] A_CORERX = 3'd4;
  localparam logic [REG_AW-1:0] A_CORETX = 3'd5;
  localparam logic [REG_AW-1:0] A_BUSTX  = 3'd6;

  localparam int FLAG_BUS  = 0;
  localparam int FLAG_CORE = 1;
  localparam int NFLAGS    = 2;
endpackage

// File: rtl/ci_dll_filter.sv
module ci_dll_filter #(
  parameter int W = 6,
  parameter logic [W-1:0] RST_CODE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] prev_o,
  output logic         hit_o
);
  logic [W-1:0] prev_q, acc_q;

  // accept on the strobe when two frames agree and differ from the latch
  assign hit_o  = sample_i && (code_i == prev_q) && (code_i != acc_q);
  assign acc_o  = acc_q;
  assign prev_o = prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= RST_CODE;
      acc_q  <= RST_CODE;
    end else if (sample_i) begin
      prev_q <= code_i;
      if (hit_o) acc_q <= code_i;
    end
  end
endmodule

// File: rtl/ci_change_det.sv
module ci_change_det #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_CODE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] last_o,
  output logic         hit_o
);
  logic [W-1:0] last_q;

  assign hit_o  = sample_i && (code_i != last_q);
  assign last_o = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        last_q <= RST_CODE;
    else if (sample_i) last_q <= code_i;
  end
endmodule

// File: rtl/ci_regs.sv
module ci_regs
  import ci_pkg::*;
#(
  parameter int W0 = CI0_W,
  parameter int W1 = CI1_W,
  parameter int DW = REG_DW,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NFLAGS-1:0] set_i,
  input  logic [W1-1:0] bus_rx_i,
  input  logic [W0-1:0] core_rx_i,
  output logic          en_o,
  output logic          sel_o,
  output logic [W0-1:0] core_tx_o,
  output logic [W1-1:0] bus_tx_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic              en_q, sel_q;
  logic [NFLAGS-1:0] flag_q, mask_q;
  logic [W0-1:0]     core_tx_q;
  logic [W1-1:0]     bus_tx_q;
  logic              stat_rd;

  assign stat_rd = rd_i && (addr_i == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      sel_q     <= 1'b0;
      mask_q    <= '0;
      core_tx_q <= IDLE0;
      bus_tx_q  <= IDLE1;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL:   begin en_q <= wdata_i[0]; sel_q <= wdata_i[1]; end
        A_MASK:   mask_q    <= wdata_i[NFLAGS-1:0];
        A_CORETX: core_tx_q <= wdata_i[W0-1:0];
        A_BUSTX:  bus_tx_q  <= wdata_i[W1-1:0];
        default:  ;
      endcase
    end
  end

  // set has priority over the read-clear
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & {NFLAGS{~stat_rd}}) | set_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o[1:0]        = {sel_q, en_q};
      A_STAT:   rdata_o[NFLAGS-1:0] = flag_q;
      A_MASK:   rdata_o[NFLAGS-1:0] = mask_q;
      A_BUSRX:  rdata_o[W1-1:0]     = bus_rx_i;
      A_CORERX: rdata_o[W0-1:0]     = core_rx_i;
      A_CORETX: rdata_o[W0-1:0]     = core_tx_q;
      A_BUSTX:  rdata_o[W1-1:0]     = bus_tx_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o     = |(flag_q & mask_q);
  assign en_o      = en_q;
  assign sel_o     = sel_q;
  assign core_tx_o = core_tx_q;
  assign bus_tx_o  = bus_tx_q;
endmodule

// File: rtl/ci_access_unit.sv
module ci_access_unit
  import ci_pkg::*;
#(
  parameter int W0 = CI0_W,
  parameter int W1 = CI1_W,
  parameter int DW = REG_DW,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  input  logic [W0-1:0] bus_ch0_rx_i,
  input  logic [W1-1:0] bus_ch1_rx_i,
  input  logic [W0-1:0] core_ind_i,
  output logic [W0-1:0] core_cmd_o,
  output logic [W0-1:0] bus_ch0_tx_o,
  output logic [W1-1:0] bus_ch1_tx_o,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam logic [W1-1:0] FILT_RST = W1'(IDLE0);

  logic          en, sel, own_ch0, own_ch1;
  logic [W0-1:0] core_tx, core_last;
  logic [W1-1:0] bus_tx, bus_code, bus_acc, bus_prev;
  logic          bus_hit, core_hit;
  logic [NFLAGS-1:0] set_flags;
  logic [W0-1:0] core_cmd_q, bus0_q;
  logic [W1-1:0] bus1_q;

  assign own_ch0  = en && !sel;
  assign own_ch1  = en && sel;
  assign bus_code = sel ? bus_ch1_rx_i : W1'(bus_ch0_rx_i);

  ci_dll_filter #(.W(W1), .RST_CODE(FILT_RST)) u_filt (
    .clk(clk), .rst_n(rst_n), .sample_i(frame_i), .code_i(bus_code),
    .acc_o(bus_acc), .prev_o(bus_prev), .hit_o(bus_hit)
  );

  ci_change_det #(.W(W0), .RST_CODE(IDLE0)) u_cdet (
    .clk(clk), .rst_n(rst_n), .sample_i(frame_i), .code_i(core_ind_i),
    .last_o(core_last), .hit_o(core_hit)
  );

  always_comb begin
    set_flags            = '0;
    set_flags[FLAG_BUS]  = bus_hit && en;
    set_flags[FLAG_CORE] = core_hit && en;
  end

  ci_regs #(.W0(W0), .W1(W1), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .set_i(set_flags),
    .bus_rx_i(bus_acc), .core_rx_i(core_last), .en_o(en), .sel_o(sel),
    .core_tx_o(core_tx), .bus_tx_o(bus_tx), .rdata_o(reg_rdata_o),
    .irq_o(irq_o)
  );

  // frame-aligned output stage: codes move only on a frame strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_cmd_q <= IDLE0;
      bus0_q     <= IDLE0;
      bus1_q     <= IDLE1;
    end else if (frame_i) begin
      core_cmd_q <= own_ch0 ? core_tx : bus_ch0_rx_i;
      bus0_q     <= own_ch0 ? bus_tx[W0-1:0] : core_ind_i;
      bus1_q     <= own_ch1 ? bus_tx : IDLE1;
    end
  end

  assign core_cmd_o   = core_cmd_q;
  assign bus_ch0_tx_o = bus0_q;
  assign bus_ch1_tx_o = bus1_q;
endmodule

// File: rtl/ci_access_unit_chk.sv
module ci_access_unit_chk #(
  parameter int W0 = 4,
  parameter int W1 = 6,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_i,
  input logic [W0-1:0] bus_ch0_rx_i,
  input logic [W0-1:0] core_cmd_o,
  input logic [W1-1:0] bus_ch1_tx_o,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [AW-1:0] reg_addr_i,
  input logic          irq_o,
  input logic          en,
  input logic          sel,
  input logic [W1-1:0] bus_code,
  input logic [W1-1:0] bus_prev,
  input logic [W1-1:0] bus_acc
);
  // R6
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> ($stable(core_cmd_o) && $stable(bus_ch1_tx_o)));

  // R2
  bypass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && !en) |=> (core_cmd_o == $past(bus_ch0_rx_i)));

  // R8
  ch0_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && en && sel) |=> (core_cmd_o == $past(bus_ch0_rx_i)));

  // R4
  glitch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && (bus_code != bus_prev)) |=> $stable(bus_acc));

  // R3
  accept_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_acc) |-> $past(frame_i));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && (reg_addr_i == 3'd1) && !frame_i && !reg_wr_i) |=> !irq_o);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && !$past(reg_wr_i)) |-> $past(frame_i));
endmodule

bind ci_access_unit ci_access_unit_chk #(.W0(W0), .W1(W1), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .bus_ch0_rx_i(bus_ch0_rx_i),
  .core_cmd_o(core_cmd_o), .bus_ch1_tx_o(bus_ch1_tx_o), .reg_wr_i(reg_wr_i),
  .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i), .irq_o(irq_o), .en(en),
  .sel(sel), .bus_code(bus_code), .bus_prev(bus_prev), .bus_acc(bus_acc)
);

// File: tb/ci_access_unit_bench.sv
module ci_access_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_i = 1'b0;
  logic [3:0] bus_ch0_rx_i = 4'hF;
  logic [5:0] bus_ch1_rx_i = 6'h3F;
  logic [3:0] core_ind_i = 4'hF;
  logic [3:0] core_cmd_o, bus_ch0_tx_o;
  logic [5:0] bus_ch1_tx_o;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  ci_access_unit u_ci_access_unit (.*);

  // per frame: {channel-0 input, expected BUS_RX, expected STAT bit 0}
  localparam logic [8:0] VEC [0:11] = '{
    {4'h5, 4'h5, 1'b0}, {4'h3, 4'h5, 1'b0}, {4'h3, 4'h3, 1'b1},
    {4'h3, 4'h3, 1'b0}, {4'hA, 4'h3, 1'b0}, {4'h3, 4'h3, 1'b0},
    {4'h5, 4'h3, 1'b0}, {4'h6, 4'h3, 1'b0}, {4'h6, 4'h6, 1'b1},
    {4'h0, 4'h6, 1'b0}, {4'h0, 4'h0, 1'b1}, {4'hF, 4'h0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame();
    @(negedge clk) frame_i = 1'b1;
    @(negedge clk) frame_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk) begin reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; end
    @(negedge clk) reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk) begin reg_rd_i = 1'b1; reg_addr_i = a; end
    #1 d = reg_rdata_o;
    @(negedge clk) reg_rd_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 core_cmd", core_cmd_o, 4'hF);
    chk("R1 bus0", bus_ch0_tx_o, 4'hF);
    chk("R1 bus1", bus_ch1_tx_o, 6'h3F);
    chk("R1 irq", irq_o, 0);
    rd(3'd0, rv); chk("R1 CTRL", rv, 8'h00);
    rd(3'd1, rv); chk("R1 STAT", rv, 8'h00);
    rd(3'd3, rv); chk("R1 BUS_RX", rv, 8'h0F);
    rd(3'd5, rv); chk("R1 CORE_TX", rv, 8'h0F);
    rd(3'd6, rv); chk("R1 BUS_TX", rv, 8'h3F);

    // R2 disabled: straight through, no flags
    bus_ch0_rx_i = 4'h5; core_ind_i = 4'h9;
    frame(); frame();
    chk("R2 core_cmd", core_cmd_o, 4'h5);
    chk("R2 bus0", bus_ch0_tx_o, 4'h9);
    chk("R2 bus1", bus_ch1_tx_o, 6'h3F);
    rd(3'd1, rv); chk("R2 STAT", rv, 8'h00);

    // R6 / R7 enable, write codes, transfer at frame only
    wr(3'd2, 8'h03);
    wr(3'd0, 8'h01);
    wr(3'd5, 8'h0A);
    wr(3'd6, 8'h36);
    chk("R6 before frame", core_cmd_o, 4'h5);
    frame();
    chk("R6 core_cmd", core_cmd_o, 4'hA);
    chk("R6 bus0", bus_ch0_tx_o, 4'h6);
    chk("R8 bus1 idle ch0", bus_ch1_tx_o, 6'h3F);
    frame(); frame(); frame();
    chk("R7 core_cmd kept", core_cmd_o, 4'hA);
    chk("R7 bus0 kept", bus_ch0_tx_o, 4'h6);

    // R3 / R4 stability filter table
    for (int i = 0; i < 12; i++) begin
      bus_ch0_rx_i = VEC[i][8:5];
      frame();
      rd(3'd1, rv); chk("R3 R4 STAT", rv, {7'd0, VEC[i][0]});
      rd(3'd3, rv); chk("R3 R4 BUS_RX", rv, {4'd0, VEC[i][4:1]});
    end

    // R5 core change, R10 irq, R9 clear on read
    bus_ch0_rx_i = 4'h0; core_ind_i = 4'h2;
    frame();
    chk("R10 irq on", irq_o, 1);
    rd(3'd4, rv); chk("R5 CORE_RX", rv, 8'h02);
    rd(3'd1, rv); chk("R5 STAT", rv, 8'h02);
    chk("R9 irq cleared", irq_o, 0);
    rd(3'd1, rv); chk("R9 STAT cleared", rv, 8'h00);

    // R10 mask hides core flag
    wr(3'd2, 8'h01);
    core_ind_i = 4'h4;
    frame();
    chk("R10 masked irq", irq_o, 0);
    rd(3'd1, rv); chk("R10 STAT still", rv, 8'h02);

    // R8 channel 1
    wr(3'd0, 8'h03);
    wr(3'd6, 8'h15);
    bus_ch0_rx_i = 4'h7; bus_ch1_rx_i = 6'h2A;
    frame();
    chk("R8 core_cmd through", core_cmd_o, 4'h7);
    chk("R8 bus0 through", bus_ch0_tx_o, 4'h4);
    chk("R8 bus1", bus_ch1_tx_o, 6'h15);
    rd(3'd3, rv); chk("R8 BUS_RX one frame", rv, 8'h00);
    frame();
    rd(3'd1, rv); chk("R8 STAT", rv, 8'h01);
    rd(3'd3, rv); chk("R8 BUS_RX", rv, 8'h2A);

    // R9 set and read in the same cycle: set survives
    bus_ch1_rx_i = 6'h11;
    frame();
    @(negedge clk) begin frame_i = 1'b1; reg_rd_i = 1'b1; reg_addr_i = 3'd1; end
    #1 chk("R9 read before set", reg_rdata_o, 8'h00);
    @(negedge clk) begin frame_i = 1'b0; reg_rd_i = 1'b0; end
    rd(3'd1, rv); chk("R9 set wins", rv, 8'h01);
    rd(3'd3, rv); chk("R9 BUS_RX", rv, 8'h11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule